// File: doc/BRIEF.md
# Single-Shunt Phase Current Reconstruction

This block turns conversions of the DC-link shunt current into the three motor phase currents. An inverter with a single shunt shows one phase current on the link during each active switching state. Which phase, and with which sign, depends on the active state, so every conversion arrives tagged with the sector, the kind of active state it was taken in, the PWM half it belongs to, and how long that state lasted.

In each half of a symmetric PWM period, the block files the two samples into four slots. The slots are indexed by half and by state kind. When the period closes, the block reconstructs the missing third phase from the zero-sum rule. It then averages the two half-period estimates and publishes signed U, V and W currents with a one-cycle valid pulse. If any sample is missing, too short or inconsistent, the previous currents are kept and the pulse is withheld.

Top module: `shunt_recon`

## Requirements
- R1: While `rst` is high and in the first cycle after it, all three current outputs are zero and `cur_valid` is low.
- R2: A sample with `smp_two_high`=0 (one leg high, two low) carries the positive current of the phase that is high. For sector codes 0,1,2,3,4,5 that phase is U,V,V,W,W,U.
- R3: A sample with `smp_two_high`=1 (two legs high, one low) carries the negated current of the phase that is low. For sector codes 0..5 that phase is W,W,U,U,V,V.
- R4: Within each half, the unmeasured phase is the negated sum of the two measured ones. A published set therefore sums to 0 or -1, the -1 coming from the rounding in R5.
- R5: Each published phase current is the sum of its two half-period estimates, shifted right arithmetically by one bit (floor of the mean). Nothing overflows over the full input range.
- R6: `cur_valid` is high for exactly the one cycle after a `period_end` cycle in which all four slots are usable. The outputs take their new values in that same cycle.
- R7: A sample whose `smp_dwell` is below `min_dwell` is unusable. A period containing one keeps all three outputs unchanged and gives no valid pulse. A dwell equal to the minimum is usable.
- R8: A missing slot, or a sample with sector code 6 or 7, also makes the period fail as in R7.
- R9: A sample presented in the same cycle as `period_end` belongs to the period being closed. Every slot is empty in the cycle after a close.
- R10: A later sample for an already filled slot of the same period replaces the earlier one.
- R11: If the two samples of one half map to the same phase, the period fails as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | A conversion is presented this cycle |
| smp_data | input | ADC_W | Signed shunt current conversion |
| smp_sector | input | 3 | Sector code 0..5 (6, 7 illegal) |
| smp_two_high | input | 1 | 0: one leg high; 1: two legs high |
| smp_half | input | 1 | 0: first half of period; 1: second half |
| smp_dwell | input | DW_W | Duration of the active state, in ticks |
| min_dwell | input | DW_W | Shortest usable active-state duration |
| period_end | input | 1 | Closes the current PWM period |
| cur_u | output | ADC_W+2 | Reconstructed U phase current |
| cur_v | output | ADC_W+2 | Reconstructed V phase current |
| cur_w | output | ADC_W+2 | Reconstructed W phase current |
| cur_valid | output | 1 | One-cycle pulse when a new set is published |

## Verification
Sample capture and period closing can fall in the same cycle. That is the case where a merge bug would either lose the last sample or leak it into the next period. The bench provokes it with directed cases and in about a quarter of random periods, by presenting the final sample together with `period_end`. It judges the result by the published currents and by a following period that must fail for lack of samples. The reference model folds the sample in before it closes.

// File: rtl/shunt_pkg.sv
package shunt_pkg;

    typedef enum logic [1:0] {
        PH_U = 2'd0,
        PH_V = 2'd1,
        PH_W = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e ph;
        logic   neg;
        logic   legal;
    } route_t;

    // Phase and sign seen on the DC link for a given sector and state kind.
    function automatic route_t route_of(input logic [2:0] sec, input logic two_high);
        route_t r;
        r.legal = 1'b1;
        r.neg   = two_high;
        r.ph    = PH_U;
        case (sec)
            3'd0: r.ph = two_high ? PH_W : PH_U;
            3'd1: r.ph = two_high ? PH_W : PH_V;
            3'd2: r.ph = two_high ? PH_U : PH_V;
            3'd3: r.ph = two_high ? PH_U : PH_W;
            3'd4: r.ph = two_high ? PH_V : PH_W;
            3'd5: r.ph = two_high ? PH_V : PH_U;
            default: r.legal = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/shunt_sample_map.sv
module shunt_sample_map
    import shunt_pkg::*;
#(
    parameter int ADC_W = 12,
    parameter int DW_W  = 10
) (
    input  logic signed [ADC_W-1:0] data,
    input  logic        [2:0]       sector,
    input  logic                    two_high,
    input  logic        [DW_W-1:0]  dwell,
    input  logic        [DW_W-1:0]  min_dwell,
    output phase_e                  ph,
    output logic signed [ADC_W:0]   val,
    output logic                    usable
);
    localparam int MW = ADC_W + 1;

    route_t               r;
    logic signed [MW-1:0] ext;

    always_comb begin
        r      = route_of(sector, two_high);
        ext    = {data[ADC_W-1], data};
        ph     = r.ph;
        val    = r.neg ? -ext : ext;
        usable = r.legal && (dwell >= min_dwell);
    end
endmodule

// File: rtl/shunt_slot_store.sv
module shunt_slot_store
    import shunt_pkg::*;
#(
    parameter int MW = 13
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr,
    input  logic                 half,
    input  logic                 two_high,
    input  phase_e               ph,
    input  logic signed [MW-1:0] val,
    input  logic                 usable,
    input  logic                 close,
    output logic [3:0]           fill_q,
    output logic [3:0]           view_fill,
    output logic [3:0]           view_good,
    output phase_e               view_ph  [4],
    output logic signed [MW-1:0] view_val [4]
);
    localparam int NSLOT = 4;

    logic [NSLOT-1:0]     good_q;
    phase_e               ph_q  [NSLOT];
    logic signed [MW-1:0] val_q [NSLOT];
    logic [1:0]           idx;

    assign idx = {half, two_high};

    always_ff @(posedge clk) begin
        for (int s = 0; s < NSLOT; s++) begin
            if (rst || close) begin
                fill_q[s] <= 1'b0;
                good_q[s] <= 1'b0;
                ph_q[s]   <= PH_U;
                val_q[s]  <= '0;
            end else if (wr && idx == 2'(s)) begin
                fill_q[s] <= 1'b1;
                good_q[s] <= usable;
                ph_q[s]   <= ph;
                val_q[s]  <= val;
            end
        end
    end

    // The slot contents as they stand this cycle, including a sample that
    // arrives together with the close.
    always_comb begin
        for (int s = 0; s < NSLOT; s++) begin
            if (wr && idx == 2'(s)) begin
                view_fill[s] = 1'b1;
                view_good[s] = usable;
                view_ph[s]   = ph;
                view_val[s]  = val;
            end else begin
                view_fill[s] = fill_q[s];
                view_good[s] = good_q[s];
                view_ph[s]   = ph_q[s];
                view_val[s]  = val_q[s];
            end
        end
    end
endmodule

// File: rtl/shunt_period_combine.sv
module shunt_period_combine
    import shunt_pkg::*;
#(
    parameter int MW = 13,
    parameter int OW = 14
) (
    input  logic [3:0]           view_fill,
    input  logic [3:0]           view_good,
    input  phase_e               view_ph  [4],
    input  logic signed [MW-1:0] view_val [4],
    output logic signed [OW-1:0] avg      [3],
    output logic                 complete
);
    logic signed [OW-1:0] est [2][3];
    logic [1:0]           half_ok;

    for (genvar h = 0; h < 2; h++) begin : g_half
        localparam int SA = 2 * h;
        localparam int SB = 2 * h + 1;
        logic signed [OW-1:0] a;
        logic signed [OW-1:0] b;
        assign a = OW'(view_val[SA]);
        assign b = OW'(view_val[SB]);
        assign half_ok[h] = view_fill[SA] && view_fill[SB] &&
                            view_good[SA] && view_good[SB] &&
                            (view_ph[SA] != view_ph[SB]);
        for (genvar p = 0; p < 3; p++) begin : g_ph
            assign est[h][p] = (view_ph[SA] == phase_e'(p)) ? a :
                               (view_ph[SB] == phase_e'(p)) ? b : -(a + b);
        end
    end

    for (genvar p = 0; p < 3; p++) begin : g_avg
        logic signed [OW:0] sum;
        assign sum    = {est[0][p][OW-1], est[0][p]} + {est[1][p][OW-1], est[1][p]};
        assign avg[p] = OW'(sum >>> 1);
    end

    assign complete = &half_ok;
endmodule

// File: rtl/shunt_recon.sv
module shunt_recon
    import shunt_pkg::*;
#(
    parameter int ADC_W = 12,
    parameter int DW_W  = 10
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    smp_valid,
    input  logic signed [ADC_W-1:0] smp_data,
    input  logic        [2:0]       smp_sector,
    input  logic                    smp_two_high,
    input  logic                    smp_half,
    input  logic        [DW_W-1:0]  smp_dwell,
    input  logic        [DW_W-1:0]  min_dwell,
    input  logic                    period_end,
    output logic signed [ADC_W+1:0] cur_u,
    output logic signed [ADC_W+1:0] cur_v,
    output logic signed [ADC_W+1:0] cur_w,
    output logic                    cur_valid
);
    localparam int MW = ADC_W + 1;
    localparam int OW = ADC_W + 2;

    phase_e               m_ph;
    logic signed [MW-1:0] m_val;
    logic                 m_usable;
    logic [3:0]           fill_q;
    logic [3:0]           view_fill;
    logic [3:0]           view_good;
    phase_e               view_ph  [4];
    logic signed [MW-1:0] view_val [4];
    logic signed [OW-1:0] avg      [3];
    logic                 complete;

    shunt_sample_map #(.ADC_W(ADC_W), .DW_W(DW_W)) u_map (
        .data(smp_data), .sector(smp_sector), .two_high(smp_two_high),
        .dwell(smp_dwell), .min_dwell(min_dwell),
        .ph(m_ph), .val(m_val), .usable(m_usable)
    );

    shunt_slot_store #(.MW(MW)) u_store (
        .clk(clk), .rst(rst), .wr(smp_valid), .half(smp_half),
        .two_high(smp_two_high), .ph(m_ph), .val(m_val), .usable(m_usable),
        .close(period_end), .fill_q(fill_q), .view_fill(view_fill),
        .view_good(view_good), .view_ph(view_ph), .view_val(view_val)
    );

    shunt_period_combine #(.MW(MW), .OW(OW)) u_comb (
        .view_fill(view_fill), .view_good(view_good), .view_ph(view_ph),
        .view_val(view_val), .avg(avg), .complete(complete)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_u     <= '0;
            cur_v     <= '0;
            cur_w     <= '0;
            cur_valid <= 1'b0;
        end else begin
            cur_valid <= period_end && complete;
            if (period_end && complete) begin
                cur_u <= avg[0];
                cur_v <= avg[1];
                cur_w <= avg[2];
            end
        end
    end
endmodule

// File: rtl/shunt_recon_chk.sv
module shunt_recon_chk #(
    parameter int ADC_W = 12,
    parameter int DW_W  = 10
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    smp_valid,
    input logic        [DW_W-1:0]  smp_dwell,
    input logic        [DW_W-1:0]  min_dwell,
    input logic                    period_end,
    input logic signed [ADC_W+1:0] cur_u,
    input logic signed [ADC_W+1:0] cur_v,
    input logic signed [ADC_W+1:0] cur_w,
    input logic                    cur_valid,
    input logic [3:0]              fill_q
);
    localparam int TW = ADC_W + 4;

    logic signed [TW-1:0] tot;
    assign tot = TW'(cur_u) + TW'(cur_v) + TW'(cur_w);

    AST_VALID_AFTER_CLOSE: assert property (@(posedge clk) disable iff (rst)
        cur_valid |-> $past(period_end)); // R6
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        cur_valid && !period_end |=> !cur_valid); // R6
    AST_HOLD_NO_PUBLISH: assert property (@(posedge clk) disable iff (rst)
        !cur_valid |-> $stable(cur_u) && $stable(cur_v) && $stable(cur_w)); // R7
    AST_SHORT_DWELL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        smp_valid && (smp_dwell < min_dwell) && period_end |=> !cur_valid); // R7
    AST_ZERO_SUM: assert property (@(posedge clk) disable iff (rst)
        cur_valid |-> (tot == 0 || tot == -1)); // R4
    AST_SLOTS_CLEARED: assert property (@(posedge clk) disable iff (rst)
        $past(period_end) |-> fill_q == 4'b0000); // R9
endmodule

bind shunt_recon shunt_recon_chk #(.ADC_W(ADC_W), .DW_W(DW_W)) u_chk (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_dwell(smp_dwell),
    .min_dwell(min_dwell), .period_end(period_end), .cur_u(cur_u),
    .cur_v(cur_v), .cur_w(cur_w), .cur_valid(cur_valid), .fill_q(fill_q)
);

// File: tb/shunt_recon_test.sv
`timescale 1ns/1ps
module shunt_recon_test;
    localparam int ADC_W = 12;
    localparam int DW_W  = 10;
    localparam int OW    = ADC_W + 2;
    localparam int MIN_D = 20;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    smp_valid = 1'b0;
    logic signed [ADC_W-1:0] smp_data = '0;
    logic        [2:0]       smp_sector = '0;
    logic                    smp_two_high = 1'b0;
    logic                    smp_half = 1'b0;
    logic        [DW_W-1:0]  smp_dwell = '0;
    logic        [DW_W-1:0]  min_dwell = DW_W'(MIN_D);
    logic                    period_end = 1'b0;
    logic signed [OW-1:0]    cur_u, cur_v, cur_w;
    logic                    cur_valid;

    always #2.5 clk = ~clk;

    shunt_recon #(.ADC_W(ADC_W), .DW_W(DW_W)) uut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .smp_sector(smp_sector), .smp_two_high(smp_two_high),
        .smp_half(smp_half), .smp_dwell(smp_dwell), .min_dwell(min_dwell),
        .period_end(period_end), .cur_u(cur_u), .cur_v(cur_v),
        .cur_w(cur_w), .cur_valid(cur_valid)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;
    int m_fill [4];
    int m_good [4];
    int m_ph   [4];
    int m_val  [4];
    int e_u = 0, e_v = 0, e_w = 0, e_valid = 0;

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // R2 / R3 tables of the requirements
    function automatic int phase_of(input int sec, input bit two);
        int one_t [6] = '{0, 1, 1, 2, 2, 0};
        int two_t [6] = '{2, 2, 0, 0, 1, 1};
        if (sec > 5) return 3;
        return two ? two_t[sec] : one_t[sec];
    endfunction

    function automatic int half_est(input int h, input int p);
        int a = 2 * h;
        int b = 2 * h + 1;
        if (m_ph[a] == p) return m_val[a];
        if (m_ph[b] == p) return m_val[b];
        return -(m_val[a] + m_val[b]);
    endfunction

    task automatic model_close();
        bit ok = 1;
        for (int h = 0; h < 2; h++)
            if (!(m_fill[2*h] && m_fill[2*h+1] && m_good[2*h] && m_good[2*h+1]
                  && m_ph[2*h] != m_ph[2*h+1])) ok = 0;
        if (ok) begin
            e_u = (half_est(0, 0) + half_est(1, 0)) >>> 1;
            e_v = (half_est(0, 1) + half_est(1, 1)) >>> 1;
            e_w = (half_est(0, 2) + half_est(1, 2)) >>> 1;
        end
        e_valid = ok;
        for (int s = 0; s < 4; s++) m_fill[s] = 0;
    endtask

    // One cycle: inputs set right after a falling edge, results read at the next.
    task automatic cyc(input string tag, input bit v, input bit half, input bit two,
                       input int sec, input int data, input int dwell, input bit pend);
        smp_valid    = v;
        smp_half     = half;
        smp_two_high = two;
        smp_sector   = 3'(sec);
        smp_data     = ADC_W'(data);
        smp_dwell    = DW_W'(dwell);
        period_end   = pend;
        if (v) begin
            int s = 2 * half + two;
            m_fill[s] = 1;
            m_good[s] = (sec < 6) && (dwell >= MIN_D);
            m_ph[s]   = phase_of(sec, two);
            m_val[s]  = two ? -data : data;
        end
        if (pend) model_close();
        @(negedge clk);
        if (pend) begin
            check({tag, " valid"}, cur_valid, e_valid);
            check({tag, " u"}, cur_u, e_u);
            check({tag, " v"}, cur_v, e_v);
            check({tag, " w"}, cur_w, e_w);
        end
    endtask

    task automatic smp(input string tag, input bit half, input bit two,
                       input int sec, input int data, input int dwell);
        cyc(tag, 1, half, two, sec, data, dwell, 0);
    endtask

    task automatic close(input string tag);
        cyc(tag, 0, 0, 0, 0, 0, 0, 1);
    endtask

    task automatic idle();
        cyc("idle", 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic full_period(input string tag, input int sec, input int d0,
                               input int d1, input int d2, input int d3);
        smp(tag, 0, 0, sec, d0, 100);
        smp(tag, 0, 1, sec, d1, 100);
        smp(tag, 1, 0, sec, d2, 100);
        smp(tag, 1, 1, sec, d3, 100);
        close(tag);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int s = 0; s < 4; s++) begin
            m_fill[s] = 0; m_good[s] = 0; m_ph[s] = 0; m_val[s] = 0;
        end
        repeat (3) @(negedge clk);
        check("R1 reset valid", cur_valid, 0);
        check("R1 reset u", cur_u, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 post valid", cur_valid, 0);
        check("R1 post w", cur_w, 0);

        // R2 R3 R4: sector code 0 -> U=100, W=-30, V=-70
        full_period("R2R3R4 sec0", 0, 100, 30, 100, 30);
        check("R4 directed u", cur_u, 100);
        check("R4 directed v", cur_v, -70);
        check("R3 directed w", cur_w, -30);
        // R2 R3 for every other sector
        for (int s = 1; s < 6; s++) full_period("R2R3 sector", s, 300 + s, -150, 290, 40 * s);
        // R5 rounding, positive and negative
        full_period("R5 pos", 0, 101, 0, 100, 0);
        check("R5 floor pos", cur_u, 100);
        full_period("R5 neg", 0, -101, 0, -100, 0);
        check("R5 floor neg", cur_u, -101);
        // R5 extremes: no overflow
        full_period("R5 extreme", 0, -2048, -2048, -2048, -2048);
        full_period("R5 extreme2", 3, 2047, -2048, 2047, -2048);
        // R7 boundary: one short, then equal to the minimum
        smp("R7", 0, 0, 1, 500, 100); smp("R7", 0, 1, 1, 20, MIN_D - 1);
        smp("R7", 1, 0, 1, 500, 100); smp("R7", 1, 1, 1, 20, 100);
        close("R7 short dwell");
        smp("R7", 0, 0, 1, 500, 100); smp("R7", 0, 1, 1, 20, MIN_D);
        smp("R7", 1, 0, 1, 500, 100); smp("R7", 1, 1, 1, 20, 100);
        close("R7 equal dwell");
        // R8 missing slot, then illegal sector
        smp("R8", 0, 0, 2, 77, 100); smp("R8", 0, 1, 2, 7, 100);
        smp("R8", 1, 0, 2, 77, 100);
        close("R8 missing");
        smp("R8", 0, 0, 6, 77, 100); smp("R8", 0, 1, 2, 7, 100);
        smp("R8", 1, 0, 2, 77, 100); smp("R8", 1, 1, 2, 7, 100);
        close("R8 illegal sector");
        // R9 last sample together with the close, then an empty period
        smp("R9", 0, 0, 4, 60, 100); smp("R9", 0, 1, 4, -25, 100);
        smp("R9", 1, 0, 4, 61, 100);
        cyc("R9 merged close", 1, 1, 1, 4, -26, 100, 1);
        smp("R9", 0, 0, 4, 60, 100); smp("R9", 0, 1, 4, -25, 100);
        smp("R9", 1, 0, 4, 61, 100);
        close("R9 cleared");
        // R10 overwrite
        smp("R10", 0, 0, 5, 999, 100); smp("R10", 0, 0, 5, 12, 100);
        smp("R10", 0, 1, 5, 4, 100); smp("R10", 1, 0, 5, 12, 100);
        smp("R10", 1, 1, 5, 4, 100);
        close("R10 overwrite");
        check("R10 u", cur_u, 12);
        // R11 both samples of half 0 map to U
        smp("R11", 0, 0, 0, 40, 100); smp("R11", 0, 1, 2, 10, 100);
        smp("R11", 1, 0, 0, 40, 100); smp("R11", 1, 1, 0, 10, 100);
        close("R11 collision");

        // Random periods (R6 main path, mixed with R7/R8/R9 faults)
        for (int k = 0; k < 400; k++) begin
            int  sec = (($urandom % 30) == 0) ? 6 + ($urandom % 2) : int'($urandom % 6);
            bit  merge = (($urandom % 4) == 0);
            for (int q = 0; q < 4; q++) begin
                int  dw   = (($urandom % 25) == 0) ? int'($urandom % MIN_D) : MIN_D + int'($urandom % 900);
                int  dat  = int'($urandom % 4096) - 2048;
                bit  skip = (($urandom % 30) == 0);
                bit  last = (q == 3);
                if (last && merge && !skip)
                    cyc("R6R9 random merged", 1, 1, 1, sec, dat, dw, 1);
                else if (!skip)
                    smp("R6 random", q[1], q[0], sec, dat, dw);
                if (($urandom % 3) == 0) idle();
            end
            if (!merge) close("R6 random close");
            if (($urandom % 2) == 0) begin
                idle();
                check("R6 pulse width", cur_valid, 0);
            end
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule